// File: doc/BRIEF.md
# Scatter-Gather Audio Playback DMA Channel

This block is one playback channel that pulls audio bytes from memory by following a table of descriptors. Each descriptor occupies eight bytes and names a buffer and that buffer's length. The channel fetches a descriptor and then reads the buffer bytes one at a time. It hands each byte to a downstream consumer over a valid/ready byte stream. When a buffer is used up, the channel steps its table pointer forward and acts on the control bits that were in the descriptor.

Software drives the channel through a small byte-addressed register port. It sets a type byte, which holds the loop mode, the interrupt enables and the sample format. It writes the table base and then starts, pauses, resumes or terminates the channel. Status flags record whether the channel has reached the end of the list, a flagged descriptor or a stop descriptor. These flags are cleared by writing ones to them. A single level interrupt follows the enabled flags. Descriptors and buffer data are read through a simple request/response memory port, one 32-bit word per request.

Top module: `sgdma_playback`

## Requirements
- R1: A descriptor is two little-endian 32-bit words at the current pointer: the buffer address first, then a control word. In the control word, bit 31 is end-of-list, bit 30 is flag, bit 29 is stop and bits 23:0 are the byte length. A descriptor is fetched only when the remaining count is zero. Buffer bytes leave on the stream in ascending address order, with none lost or repeated. A memory request holds its address until its response arrives.
- R2: While `out_valid` is high and `out_ready` is low, the stream byte is held unchanged and stays offered.
- R3: When a descriptor's remaining count reaches zero, the current pointer advances by 8. Offset 0x04 reads the current pointer. Offset 0x0C reads the remaining byte count, which drops by one for each byte accepted on the stream.
- R4: Completing an end-of-list descriptor sets status bit 1. If type bit 7 (loop) is set, the pointer reloads from the base and the channel pauses with active kept set. Otherwise active clears.
- R5: Completing a flag descriptor sets status bit 0 and paused (bit 6). Completing a stop descriptor sets status bit 2 and paused.
- R6: `irq` is a level equal to (status bit 1 AND type bit 1) OR (status bit 0 AND type bit 0). It stays high until a register write removes its cause.
- R7: A write to offset 0x00 clears status bits where the data has ones. Bit 1 clears end-of-list and paused. Bit 0 clears flag and paused. Bit 2 clears paused only.
- R8: A write to offset 0x01 acts on three bits, applied in this order. Bit 7 (start) makes the status exactly active (0x80). Bit 6 (terminate) clears active and paused and sets the remaining count to zero. Bit 3 set pauses the channel: it clears active and sets paused. A write with bit 3 clear while paused resumes the channel: it sets active and clears paused.
- R9: A write to offset 0x04 stores the table base with address bit 0 forced to zero and loads the current pointer with it. The pointer is never odd. A fetch that starts with the pointer below the base first sets it to the base.
- R10: Reading offset 0x00 returns the status byte, with bit 3 equal to type bit 7. Offset 0x01 reads 0x08 while paused and 0 otherwise. Offset 0x02 reads back the type byte. `fmt_stereo` follows type bit 4 and `fmt_16bit` follows type bit 5.
- R11: Offset 0x84 reads a summary word with flag in bit 0, end-of-list in bit 4, stop in bit 8 and active in bit 12.
- R12: No new memory request is issued unless the channel is active and not paused. After reset, all status, `irq`, `mem_req` and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory read request, held until `mem_rvalid` |
| mem_addr | output | AW | Word-aligned read address |
| mem_rvalid | input | 1 | Read response valid, ends the request |
| mem_rdata | input | 32 | Little-endian read data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | 8 | Stream byte |
| fmt_stereo | output | 1 | Stereo selection from type bit 4 |
| fmt_16bit | output | 1 | 16-bit sample selection from type bit 5 |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the memory side answers each request with exactly one `mem_rvalid` pulse and never raises `mem_rvalid` without a pending request. The stimulus meets this with a responder that only answers while `mem_req` is high, after a random delay of zero to two cycles. Random `out_ready` gaps exercise the stream hold rule. The bench issues a terminate only after a pause has drained the byte in flight, so no accepted byte is dropped. Register writes fall on idle or paused channels, or are pause and resume commands, so a write never meets a completion in a way that would make the expected status ambiguous.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int LEN_W = 24;

  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h01;
  localparam logic [7:0] OFS_TYPE = 8'h02;
  localparam logic [7:0] OFS_PTR  = 8'h04;
  localparam logic [7:0] OFS_REM  = 8'h0C;
  localparam logic [7:0] OFS_SUM  = 8'h84;

  localparam int DSC_EOL = 31;
  localparam int DSC_FLG = 30;
  localparam int DSC_STP = 29;

  localparam int CTL_START = 7;
  localparam int CTL_TERM  = 6;
  localparam int CTL_PAUSE = 3;

  localparam int TYP_LOOP   = 7;
  localparam int TYP_16B    = 5;
  localparam int TYP_STEREO = 4;
  localparam int TYP_IE_EOL = 1;
  localparam int TYP_IE_FLG = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DADR, ST_DCTL, ST_DATA, ST_OUT, ST_DONE
  } eng_state_t;

  typedef struct packed {
    logic act;
    logic pau;
    logic stp;
    logic eol;
    logic flg;
  } chan_stat_t;
endpackage

// File: rtl/sgdma_rst_sync.sv
module sgdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_done,
  input  logic             ev_eol,
  input  logic             ev_flg,
  input  logic             ev_stp,
  input  logic [AW-1:0]    curr,
  input  logic [LEN_W-1:0] remain,
  output logic             run,
  output logic             loop_en,
  output logic             term,
  output logic             base_wr,
  output logic [AW-1:0]    base_val,
  output logic [AW-1:0]    base,
  output logic             fmt_stereo,
  output logic             fmt_16bit,
  output logic             irq
);
  chan_stat_t st_q, st_n;
  logic [7:0] type_q;
  logic       wr_stat, wr_ctrl, wr_type;

  assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
  assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_type  = reg_wr && (reg_addr == OFS_TYPE);
  assign base_wr  = reg_wr && (reg_addr == OFS_PTR);
  assign base_val = {reg_wdata[AW-1:1], 1'b0};
  assign term     = wr_ctrl && reg_wdata[CTL_TERM];

  // status next state: engine events first, software writes after
  always_comb begin
    st_n = st_q;
    if (ev_done) begin
      if (ev_eol) begin
        st_n.eol = 1'b1;
        if (type_q[TYP_LOOP]) st_n.pau = 1'b1;
        else                  st_n.act = 1'b0;
      end
      if (ev_flg) begin
        st_n.flg = 1'b1;
        st_n.pau = 1'b1;
      end
      if (ev_stp) begin
        st_n.stp = 1'b1;
        st_n.pau = 1'b1;
      end
    end
    if (wr_stat) begin
      if (reg_wdata[2]) st_n.pau = 1'b0;
      if (reg_wdata[1]) begin
        st_n.eol = 1'b0;
        st_n.pau = 1'b0;
      end
      if (reg_wdata[0]) begin
        st_n.flg = 1'b0;
        st_n.pau = 1'b0;
      end
    end
    if (wr_ctrl) begin
      if (reg_wdata[CTL_START]) st_n = '{act: 1'b1, default: 1'b0};
      if (reg_wdata[CTL_TERM]) begin
        st_n.act = 1'b0;
        st_n.pau = 1'b0;
      end
      if (reg_wdata[CTL_PAUSE]) begin
        st_n.act = 1'b0;
        st_n.pau = 1'b1;
      end else if (st_n.pau) begin
        st_n.act = 1'b1;
        st_n.pau = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      type_q <= '0;
      base   <= '0;
    end else begin
      st_q <= st_n;
      if (wr_type) type_q <= reg_wdata[7:0];
      if (base_wr) base   <= base_val;
    end
  end

  assign run        = st_q.act && !st_q.pau;
  assign loop_en    = type_q[TYP_LOOP];
  assign fmt_stereo = type_q[TYP_STEREO];
  assign fmt_16bit  = type_q[TYP_16B];
  assign irq        = (st_q.eol && type_q[TYP_IE_EOL]) || (st_q.flg && type_q[TYP_IE_FLG]);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_STAT: reg_rdata = {24'd0, st_q.act, st_q.pau, 2'b00, type_q[TYP_LOOP],
                             st_q.stp, st_q.eol, st_q.flg};
      OFS_CTRL: reg_rdata = {28'd0, st_q.pau, 3'b000};
      OFS_TYPE: reg_rdata = {24'd0, type_q};
      OFS_PTR:  reg_rdata = 32'(curr);
      OFS_REM:  reg_rdata = 32'(remain);
      OFS_SUM:  reg_rdata = {19'd0, st_q.act, 3'b000, st_q.stp, 3'b000, st_q.eol,
                             3'b000, st_q.flg};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             loop_en,
  input  logic             term,
  input  logic             base_wr,
  input  logic [AW-1:0]    base_val,
  input  logic [AW-1:0]    base,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             ev_done,
  output logic             ev_eol,
  output logic             ev_flg,
  output logic             ev_stp,
  output logic [AW-1:0]    curr,
  output logic [LEN_W-1:0] remain
);
  localparam logic [AW-1:0] DESC_BYTES = AW'(8);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  eng_state_t       state_q, state_n;
  logic [AW-1:0]    curr_q, curr_n, baddr_q, baddr_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic [7:0]       byte_q, byte_n;
  logic [2:0]       ctl_q, ctl_n;     // {eol, flg, stp}
  logic             kill_q, kill_n;
  logic             waiting;

  assign waiting   = (state_q == ST_DADR) || (state_q == ST_DCTL) || (state_q == ST_DATA);
  assign mem_req   = waiting;
  assign out_valid = (state_q == ST_OUT);
  assign out_data  = byte_q;
  assign ev_done   = (state_q == ST_DONE);
  assign ev_eol    = ctl_q[2];
  assign ev_flg    = ctl_q[1];
  assign ev_stp    = ctl_q[0];
  assign curr      = curr_q;
  assign remain    = rem_q;

  always_comb begin
    unique case (state_q)
      ST_DADR: mem_addr = curr_q;
      ST_DCTL: mem_addr = curr_q + WORD_BYTES;
      ST_DATA: mem_addr = {baddr_q[AW-1:2], 2'b00};
      default: mem_addr = '0;
    endcase
  end

  always_comb begin
    state_n = state_q;
    curr_n  = curr_q;
    baddr_n = baddr_q;
    rem_n   = rem_q;
    byte_n  = byte_q;
    ctl_n   = ctl_q;
    kill_n  = kill_q;
    unique case (state_q)
      ST_IDLE: begin
        if (run) begin
          if (rem_q == '0) begin
            if (curr_q < base) curr_n = base;
            state_n = ST_DADR;
          end else begin
            state_n = ST_DATA;
          end
        end
      end
      ST_DADR: begin
        if (mem_rvalid) begin
          if (kill_q) begin
            kill_n  = 1'b0;
            state_n = ST_IDLE;
          end else begin
            baddr_n = mem_rdata[AW-1:0];
            state_n = ST_DCTL;
          end
        end
      end
      ST_DCTL: begin
        if (mem_rvalid) begin
          if (kill_q) begin
            kill_n  = 1'b0;
            state_n = ST_IDLE;
          end else begin
            rem_n   = mem_rdata[LEN_W-1:0];
            ctl_n   = {mem_rdata[DSC_EOL], mem_rdata[DSC_FLG], mem_rdata[DSC_STP]};
            state_n = (mem_rdata[LEN_W-1:0] == '0) ? ST_DONE : ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (mem_rvalid) begin
          if (kill_q) begin
            kill_n  = 1'b0;
            state_n = ST_IDLE;
          end else begin
            byte_n  = mem_rdata[{baddr_q[1:0], 3'b000} +: 8];
            state_n = ST_OUT;
          end
        end
      end
      ST_OUT: begin
        if (out_ready) begin
          baddr_n = baddr_q + AW'(1);
          rem_n   = rem_q - LEN_W'(1);
          state_n = (rem_q == LEN_W'(1)) ? ST_DONE : ST_IDLE;
        end
      end
      ST_DONE: begin
        curr_n  = (ctl_q[2] && loop_en) ? base : curr_q + DESC_BYTES;
        rem_n   = '0;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
    if (term) begin
      rem_n = '0;
      if (waiting && !mem_rvalid) begin
        kill_n  = 1'b1;
        state_n = state_q;
      end else if (state_q != ST_DONE) begin
        kill_n  = 1'b0;
        state_n = ST_IDLE;
      end
    end
    if (base_wr) curr_n = base_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      curr_q  <= '0;
      baddr_q <= '0;
      rem_q   <= '0;
      byte_q  <= '0;
      ctl_q   <= '0;
      kill_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      curr_q  <= curr_n;
      rem_q   <= rem_n;
      kill_q  <= kill_n;
      if (state_n != state_q || state_q == ST_OUT) baddr_q <= baddr_n;
      if (state_q == ST_DATA && mem_rvalid)        byte_q  <= byte_n;
      if (state_q == ST_DCTL && mem_rvalid)        ctl_q   <= ctl_n;
    end
  end
endmodule

// File: rtl/sgdma_playback.sv
module sgdma_playback
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          fmt_stereo,
  output logic          fmt_16bit,
  output logic          irq
);
  logic             rst_n_s;
  logic             run_w, loop_w, term_w, base_wr_w;
  logic [AW-1:0]    base_val_w, base_w, curr_w;
  logic [LEN_W-1:0] remain_w;
  logic             ev_done_w, ev_eol_w, ev_flg_w, ev_stp_w;

  sgdma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  sgdma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done_w), .ev_eol(ev_eol_w), .ev_flg(ev_flg_w), .ev_stp(ev_stp_w),
    .curr(curr_w), .remain(remain_w),
    .run(run_w), .loop_en(loop_w), .term(term_w),
    .base_wr(base_wr_w), .base_val(base_val_w), .base(base_w),
    .fmt_stereo(fmt_stereo), .fmt_16bit(fmt_16bit), .irq(irq)
  );

  sgdma_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n_s),
    .run(run_w), .loop_en(loop_w), .term(term_w),
    .base_wr(base_wr_w), .base_val(base_val_w), .base(base_w),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ev_done(ev_done_w), .ev_eol(ev_eol_w), .ev_flg(ev_flg_w), .ev_stp(ev_stp_w),
    .curr(curr_w), .remain(remain_w)
  );
endmodule

// File: rtl/sgdma_playback_chk.sv
module sgdma_playback_chk #(
  parameter int AW    = 32,
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             mem_req,
  input logic             mem_rvalid,
  input logic [AW-1:0]    mem_addr,
  input logic             irq,
  input logic             reg_wr,
  input logic             run,
  input logic             term,
  input logic [AW-1:0]    curr,
  input logic [LEN_W-1:0] remain
);
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !term |=> out_valid && $stable(out_data)); // R2

  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !term |=> remain == $past(remain) - LEN_W'(1)); // R3

  AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(run)); // R12

  AST_MEM_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R1

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !reg_wr |=> irq); // R6

  AST_PTR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !curr[0]); // R9
endmodule

bind sgdma_playback sgdma_playback_chk #(.AW(AW), .LEN_W(sgdma_pkg::LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .mem_addr(mem_addr),
  .irq(irq), .reg_wr(reg_wr),
  .run(run_w), .term(term_w), .curr(curr_w), .remain(remain_w)
);

// File: tb/sgdma_playback_tb.sv
module sgdma_playback_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid;
  logic [31:0]   mem_rdata;
  logic          out_valid;
  logic          out_ready;
  logic [7:0]    out_data;
  logic          fmt_stereo;
  logic          fmt_16bit;
  logic          irq;

  int errs = 0;
  int checks = 0;
  int exp_n = 0;
  int rx_cnt = 0;
  logic [7:0] exp_b [0:511];
  logic [7:0] mem_b [0:1023];

  sgdma_playback #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fmt_stereo(fmt_stereo), .fmt_16bit(fmt_16bit), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  function automatic logic [31:0] exp_status(input bit act, input bit pau, input bit stp,
                                             input bit eol, input bit flg, input bit trig);
    return {24'd0, act, pau, 2'b00, trig, stp, eol, flg};
  endfunction

  function automatic logic [31:0] exp_sum(input bit act, input bit stp, input bit eol, input bit flg);
    return (32'(act) << 12) | (32'(stp) << 8) | (32'(eol) << 4) | 32'(flg);
  endfunction

  function automatic logic [31:0] rd_word(input logic [AW-1:0] a);
    int b;
    b = int'(a[9:0]) & 'h3FC;
    return {mem_b[b+3], mem_b[b+2], mem_b[b+1], mem_b[b]};
  endfunction

  // memory responder
  initial begin
    int wt;
    wt = 0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_req) begin
        if (wt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd_word(mem_addr);
          wt = int'($urandom % 3);
        end else wt--;
      end
    end
  end

  // stream sink with random backpressure
  initial begin
    logic       prev_stall;
    logic [7:0] prev_data;
    prev_stall = 1'b0;
    prev_data  = '0;
    out_ready  = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        out_ready  = 1'b0;
        prev_stall = 1'b0;
      end else begin
        if (prev_stall) begin
          check("R2 held valid", 32'(out_valid), 32'd1);
          check("R2 held data", 32'(out_data), 32'(prev_data));
        end
        out_ready = ($urandom % 4) != 0;
        if (out_valid && out_ready) begin
          if (rx_cnt < exp_n) check("R1 stream byte", 32'(out_data), 32'(exp_b[rx_cnt]));
          else                check("R1 unexpected byte", 32'(out_data), 32'hFFFF_FFFF);
          rx_cnt++;
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string tag);
    int k;
    k = 0;
    while (!irq && k < 2000) begin @(negedge clk); k++; end
    check(tag, 32'(irq), 32'd1);
  endtask

  task automatic wait_reg(input string tag, input logic [7:0] a, input logic [31:0] m, input logic [31:0] v);
    logic [31:0] d;
    int k;
    k = 0;
    reg_read(a, d);
    while (((d & m) != v) && k < 2000) begin @(negedge clk); reg_read(a, d); k++; end
    check(tag, d & m, v);
  endtask

  task automatic put_desc(input int tbl, input int idx, input logic [31:0] buf_a, input logic [31:0] ctl);
    for (int i = 0; i < 4; i++) begin
      mem_b[tbl + idx*8 + i]     = buf_a[8*i +: 8];
      mem_b[tbl + idx*8 + 4 + i] = ctl[8*i +: 8];
    end
  endtask

  task automatic fill_buf(input int a, input int len);
    for (int i = 0; i < len; i++) mem_b[a + i] = 8'($urandom);
  endtask

  task automatic add_exp(input int a, input int len);
    for (int i = 0; i < len; i++) begin
      exp_b[exp_n] = mem_b[a + i];
      exp_n++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int tbl, da, l0, l1, l2, mark, c1;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem_b[i] = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // reset state
    reg_read(8'h00, d); check("R12 reset status", d, 32'h0);
    reg_read(8'h84, d); check("R11 reset summary", d, 32'h0);
    check("R12 reset irq", 32'(irq), 32'd0);
    check("R12 reset mem_req", 32'(mem_req), 32'd0);
    check("R12 reset out_valid", 32'(out_valid), 32'd0);

    // random three-descriptor lists: plain, flag, end-of-list
    for (int r = 0; r < 3; r++) begin
      tbl = r * 32;
      da  = 'h100 + r * 'h50 + int'($urandom % 4);
      l0  = 1 + int'($urandom % 12);
      l1  = 1 + int'($urandom % 12);
      l2  = 1 + int'($urandom % 12);
      put_desc(tbl, 0, 32'(da), 32'(l0));
      put_desc(tbl, 1, 32'(da + l0), (32'd1 << 30) | 32'(l1));
      put_desc(tbl, 2, 32'(da + l0 + l1), (32'd1 << 31) | 32'(l2));
      fill_buf(da, l0 + l1 + l2);
      mark = exp_n;
      add_exp(da, l0 + l1 + l2);
      reg_write(8'h02, 32'h03);
      reg_write(8'h04, 32'(tbl) | 32'h1);
      reg_read(8'h04, d); check("R9 base bit0 cleared", d, 32'(tbl));
      reg_write(8'h01, 32'h80);
      reg_read(8'h00, d); check("R8 start status", d, 32'h80);
      wait_irq("R6 flag irq");
      reg_read(8'h00, d); check("R5 flag status", d, exp_status(1, 1, 0, 0, 1, 0));
      reg_read(8'h04, d); check("R3 pointer after two", d, 32'(tbl + 16));
      reg_read(8'h0C, d); check("R3 remaining zero", d, 32'h0);
      check("R1 count at flag", 32'(rx_cnt), 32'(mark + l0 + l1));
      idle(15);
      check("R12 no move while paused", 32'(rx_cnt), 32'(mark + l0 + l1));
      check("R12 no request while paused", 32'(mem_req), 32'd0);
      reg_read(8'h84, d); check("R11 summary flag", d, exp_sum(1, 0, 0, 1));
      reg_read(8'h01, d); check("R10 paused readback", d, 32'h08);
      reg_write(8'h00, 32'h01);
      check("R6 irq cleared", 32'(irq), 32'd0);
      reg_read(8'h00, d); check("R7 flag cleared", d, 32'h80);
      wait_irq("R6 eol irq");
      reg_read(8'h00, d); check("R4 eol no loop", d, exp_status(0, 0, 0, 1, 0, 0));
      reg_read(8'h04, d); check("R3 pointer after three", d, 32'(tbl + 24));
      check("R1 all bytes", 32'(rx_cnt), 32'(exp_n));
      reg_read(8'h84, d); check("R11 summary eol", d, exp_sum(0, 0, 1, 0));
      reg_write(8'h00, 32'h02);
      check("R7 eol clear drops irq", 32'(irq), 32'd0);
    end

    // loop mode
    tbl = 'h80; da = 'h301; l0 = 3 + int'($urandom % 7);
    put_desc(tbl, 0, 32'(da), (32'd1 << 31) | 32'(l0));
    fill_buf(da, l0);
    add_exp(da, l0);
    reg_write(8'h02, 32'h82);
    reg_write(8'h04, 32'(tbl));
    reg_write(8'h01, 32'h80);
    reg_read(8'h00, d); check("R10 trig bit follows loop", d, 32'h88);
    wait_irq("R4 loop irq");
    reg_read(8'h00, d); check("R4 loop status", d, exp_status(1, 1, 0, 1, 0, 1));
    reg_read(8'h04, d); check("R4 pointer reloaded", d, 32'(tbl));
    check("R1 loop pass one", 32'(rx_cnt), 32'(exp_n));
    add_exp(da, l0);
    reg_write(8'h00, 32'h02);
    reg_read(8'h00, d); check("R7 loop resume", d, 32'h88);
    idle(2);
    wait_irq("R4 loop irq again");
    check("R4 loop pass two", 32'(rx_cnt), 32'(exp_n));
    reg_write(8'h01, 32'h40);
    reg_read(8'h00, d); check("R8 terminate keeps eol", d, exp_status(0, 0, 0, 1, 0, 1));
    check("R6 irq held until clear", 32'(irq), 32'd1);
    reg_write(8'h00, 32'h02);
    reg_write(8'h02, 32'h00);

    // stop descriptor then end of list, no interrupt enables
    tbl = 'hA0;
    put_desc(tbl, 0, 32'h340, (32'd1 << 29) | 32'd4);
    put_desc(tbl, 1, 32'h352, (32'd1 << 31) | 32'd3);
    fill_buf('h340, 4); fill_buf('h352, 3);
    add_exp('h340, 4); add_exp('h352, 3);
    reg_write(8'h04, 32'(tbl));
    reg_write(8'h01, 32'h80);
    wait_reg("R5 stop pauses", 8'h01, 32'hFF, 32'h08);
    reg_read(8'h00, d); check("R5 stop status", d, exp_status(1, 1, 1, 0, 0, 0));
    check("R6 no irq when disabled", 32'(irq), 32'd0);
    check("R1 count at stop", 32'(rx_cnt), 32'(exp_n - 3));
    reg_write(8'h00, 32'h04);
    reg_read(8'h00, d); check("R7 stop clears paused only", d, exp_status(1, 0, 1, 0, 0, 0));
    wait_reg("R4 goes inactive", 8'h00, 32'h80, 32'h00);
    reg_read(8'h00, d); check("R4 stop then eol status", d, exp_status(0, 0, 1, 1, 0, 0));
    reg_read(8'h84, d); check("R11 summary stop eol", d, exp_sum(0, 1, 1, 0));
    check("R1 count stop list", 32'(rx_cnt), 32'(exp_n));
    reg_write(8'h00, 32'h07);

    // pause, resume, terminate on a long buffer
    tbl = 'hC0;
    put_desc(tbl, 0, 32'h380, 32'd40);
    fill_buf('h380, 40);
    mark = exp_n;
    add_exp('h380, 40);
    reg_write(8'h02, 32'h30);
    check("R10 stereo select", 32'(fmt_stereo), 32'd1);
    check("R10 16-bit select", 32'(fmt_16bit), 32'd1);
    reg_write(8'h04, 32'(tbl));
    reg_write(8'h01, 32'h80);
    idle(30);
    reg_write(8'h01, 32'h08);
    reg_read(8'h00, d); check("R8 pause status", d, 32'h40);
    idle(20);
    c1 = rx_cnt - mark;
    reg_read(8'h0C, d); check("R3 remaining after pause", d, 32'(40 - c1));
    idle(15);
    check("R12 paused no bytes", 32'(rx_cnt - mark), 32'(c1));
    check("R12 paused no request", 32'(mem_req), 32'd0);
    reg_write(8'h01, 32'h00);
    reg_read(8'h00, d); check("R8 resume status", d, 32'h80);
    idle(20);
    reg_write(8'h01, 32'h08);
    idle(20);
    check("R8 resume moved data", 32'(rx_cnt - mark > c1), 32'd1);
    reg_write(8'h01, 32'h40);
    reg_read(8'h00, d); check("R8 terminate status", d, 32'h00);
    reg_read(8'h0C, d); check("R8 terminate remaining", d, 32'h0);
    exp_n = rx_cnt;
    reg_write(8'h02, 32'h10);
    reg_read(8'h02, d); check("R10 type readback", d, 32'h10);
    check("R10 stereo only", 32'(fmt_stereo), 32'd1);
    check("R10 8-bit", 32'(fmt_16bit), 32'd0);

    idle(5);
    report();
    $finish;
  end
endmodule